// File: doc/BRIEF.md
# Low-Rate Clock Timer with Tap Interrupts

This block is an 8-bit binary up-counter that advances once per 256 Hz tick. The tick is a pulse one system clock wide, generated in the system clock domain. Each counter bit is a divided clock. Bit 0 runs at 128 Hz and every higher bit runs at half the rate of the bit below it, so bit 7 is the 1 Hz signal. The block watches four of these taps: the 32 Hz, 8 Hz, 2 Hz and 1 Hz taps, which are counter bits 2, 4, 6 and 7. Whenever one of them falls from 1 to 0, the block sets a sticky flag for that tap.

Software controls the block through four byte-wide registers:

- a control register with a run bit and a counter-clear strobe;
- a read-only view of the count;
- the four flags, each cleared by writing 1 to it;
- the four matching enable bits.

A single interrupt request is high while any flag is set whose enable bit is also set. The count can be read while the counter runs. Software that needs a coherent value reads it twice and accepts the value when the two reads agree.

Top module: `lrc_timer`

## Requirements
- R1: After reset the count is 0x00, all flags and enables are 0, the run bit reads 0 and `irq_o` is low.
- R2: While running, each tick adds exactly 1 to the count, and 0xFF wraps to 0x00.
- R3: While stopped, ticks leave the count unchanged and set no flag.
- R4: Control bit 0 at address 0 requests run (1) or stop (0). The requested value takes effect for counting from the next cycle. The value read back from bit 0 changes only at the next tick, so it may lag the written value.
- R5: A tick that drives counter bit 2, 4, 6 or 7 from 1 to 0 sets flag bit 0, 1, 2 or 3 respectively. The flags are read at address 2.
- R6: Writing 1 to a flag bit at address 2 clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R7: If a flag is set by a tap edge and cleared by a write in the same cycle, the flag ends up set.
- R8: Enable bits [3:0] are at address 3. Flags are set whether or not they are enabled. `irq_o` is high exactly while some flag and its enable bit are both 1, so enabling a pending flag raises `irq_o` at once.
- R9: Writing 1 to control bit 1 (address 0) sets the count to 0x00 and leaves the flags, the enables and the run state unchanged. Bit 1 always reads 0.
- R10: The count is read at address 1. Writes to address 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 256 Hz count pulse, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Register writes and ticks take effect at the clock edge on which they are sampled. The read data and `irq_o` decode the registers with no further delay, so every result can be observed in the same clock cycle, right after that edge. The run read-back is the exception: it changes only at the next tick edge after it is written. The bench therefore applies each stimulus just after an edge and updates its own model at the following edge. It queues the expected value at that point and compares the outputs at the falling edge of the same cycle.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  parameter int unsigned CNT_W  = 8;
  parameter int unsigned NUM_IRQ = 4;
  parameter int unsigned ADDR_W = 2;
  parameter int unsigned DATA_W = 8;

  // Counter bit watched by each flag: 32 Hz, 8 Hz, 2 Hz, 1 Hz
  parameter int unsigned TAP_BIT [NUM_IRQ] = '{2, 4, 6, 7};

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_COUNT = 2'd1,
    REG_FLAGS = 2'd2,
    REG_ENA   = 2'd3
  } reg_addr_e;

  localparam int unsigned CTRL_RUN = 0;
  localparam int unsigned CTRL_CLR = 1;

  // Bit k of a counter drops on increment when bits k..0 are all ones
  function automatic logic bit_falls(input logic [CNT_W-1:0] c, input int unsigned k);
    logic all_ones;
    all_ones = 1'b1;
    for (int unsigned i = 0; i < CNT_W; i++) begin
      if (i <= k) all_ones = all_ones & c[i];
    end
    return all_ones;
  endfunction

  function automatic logic [NUM_IRQ-1:0] next_flags(input logic [NUM_IRQ-1:0] cur,
                                                    input logic [NUM_IRQ-1:0] clr_mask,
                                                    input logic [NUM_IRQ-1:0] set_ev);
    return (cur & ~clr_mask) | set_ev;
  endfunction
endpackage

// File: rtl/ctmr_runctl.sv
module ctmr_runctl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic wr_run_i,
  input  logic run_wdata_i,
  output logic run_req_o,
  output logic run_act_o
);
  logic run_req_q;
  logic run_act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_req_q <= 1'b0;
      run_act_q <= 1'b0;
    end else begin
      if (wr_run_i) run_req_q <= run_wdata_i;
      if (tick_i)   run_act_q <= run_req_q;
    end
  end

  assign run_req_o = run_req_q;
  assign run_act_o = run_act_q;

  AST_RUN_READBACK_LAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(run_act_o)); // R4
endmodule

// File: rtl/ctmr_counter.sv
module ctmr_counter
  import ctmr_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  input  logic         clr_i,
  output logic [W-1:0] count_o,
  output logic [W-1:0] fall_ev_o
);
  logic [W-1:0] count_q;
  logic         step;

  assign step = adv_i & ~clr_i;

  always_ff @(posedge clk) begin
    if (!rst_n)      count_q <= '0;
    else if (clr_i)  count_q <= '0;
    else if (adv_i)  count_q <= count_q + W'(1);
  end

  for (genvar k = 0; k < W; k++) begin : g_fall
    assign fall_ev_o[k] = step & bit_falls(count_q, k);
  end

  assign count_o = count_q;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> count_o == W'($past(count_o) + W'(1))); // R2
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !clr_i) |=> $stable(count_o)); // R3
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> count_o == '0); // R9
endmodule

// File: rtl/ctmr_irqs.sv
module ctmr_irqs
  import ctmr_pkg::*;
#(
  parameter int unsigned N = NUM_IRQ
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_ev_i,
  input  logic         clr_wr_i,
  input  logic [N-1:0] clr_mask_i,
  input  logic         en_wr_i,
  input  logic [N-1:0] en_wdata_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] enables_o,
  output logic         irq_o
);
  logic [N-1:0] flags_q;
  logic [N-1:0] en_q;
  logic [N-1:0] eff_clr;

  assign eff_clr = clr_wr_i ? clr_mask_i : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
    end else begin
      flags_q <= next_flags(flags_q, eff_clr, set_ev_i);
      if (en_wr_i) en_q <= en_wdata_i;
    end
  end

  assign flags_o   = flags_q;
  assign enables_o = en_q;
  assign irq_o     = |(flags_q & en_q);

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_ev_i) |=> ((flags_o & $past(set_ev_i)) == $past(set_ev_i))); // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr_i |=> ((flags_o & $past(clr_mask_i & ~set_ev_i)) == '0)); // R6
  AST_IRQ_ON_ENABLED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(set_ev_i & en_q)) && !en_wr_i) |=> irq_o); // R8
endmodule

// File: rtl/lrc_timer.sv
module lrc_timer
  import ctmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic               wr_ctrl, wr_flags, wr_ena;
  logic               run_req, run_act;
  logic               adv, clr_cnt;
  logic [CNT_W-1:0]   count;
  logic [CNT_W-1:0]   fall_ev;
  logic [NUM_IRQ-1:0] set_ev;
  logic [NUM_IRQ-1:0] flags, enables;

  assign wr_ctrl  = wr_en_i && (addr_i == REG_CTRL);
  assign wr_flags = wr_en_i && (addr_i == REG_FLAGS);
  assign wr_ena   = wr_en_i && (addr_i == REG_ENA);
  assign clr_cnt  = wr_ctrl && wdata_i[CTRL_CLR];
  assign adv      = tick_i && run_req;

  ctmr_runctl u_runctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .wr_run_i   (wr_ctrl),
    .run_wdata_i(wdata_i[CTRL_RUN]),
    .run_req_o  (run_req),
    .run_act_o  (run_act)
  );

  ctmr_counter #(.W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv_i    (adv),
    .clr_i    (clr_cnt),
    .count_o  (count),
    .fall_ev_o(fall_ev)
  );

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_tap
    assign set_ev[i] = fall_ev[TAP_BIT[i]];
  end

  ctmr_irqs #(.N(NUM_IRQ)) u_irqs (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_ev_i  (set_ev),
    .clr_wr_i  (wr_flags),
    .clr_mask_i(wdata_i[NUM_IRQ-1:0]),
    .en_wr_i   (wr_ena),
    .en_wdata_i(wdata_i[NUM_IRQ-1:0]),
    .flags_o   (flags),
    .enables_o (enables),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL:  rdata_o[CTRL_RUN]  = run_act;
      REG_COUNT: rdata_o[CNT_W-1:0] = count;
      REG_FLAGS: rdata_o[NUM_IRQ-1:0] = flags;
      REG_ENA:   rdata_o[NUM_IRQ-1:0] = enables;
      default:   rdata_o = '0;
    endcase
  end

  AST_NO_FLAG_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_req |-> (set_ev == '0)); // R3
  AST_COUNT_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == REG_COUNT && !tick_i) |=> $stable(count)); // R10
endmodule

// File: tb/test_lrc_timer.sv
module test_lrc_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       irq_o;

  lrc_timer i_lrc_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  logic chk_on = 1'b0;
  bit finished = 1'b0;

  // Bench model
  logic [7:0] m_cnt = 8'd0;
  logic [3:0] m_flags = 4'd0;
  logic [3:0] m_en = 4'd0;
  logic       m_req = 1'b0;
  logic       m_act = 1'b0;

  function automatic logic [3:0] tap_drops(input logic [7:0] old);
    logic [7:0] dropped;
    dropped = old & ~(old + 8'd1);
    return {dropped[7], dropped[6], dropped[4], dropped[2]};
  endfunction

  task automatic push_read(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    addr_i = a;
    q.push_back(it);
    chk_on = 1'b1;
    @(posedge clk); #1;
    chk_on = 1'b0;
  endtask

  task automatic push_irq(input logic e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = {7'd0, e}; it.tag = tag;
    q.push_back(it);
    chk_on = 1'b1;
    @(posedge clk); #1;
    chk_on = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk);
    case (a)
      2'd0: begin m_req = d[0]; if (d[1]) m_cnt = 8'd0; end
      2'd2: m_flags = m_flags & ~d[3:0];
      2'd3: m_en = d[3:0];
      default: ;
    endcase
    #1 wr_en_i = 1'b0;
  endtask

  task automatic tick_with_clear(input bit do_clr, input logic [3:0] mask);
    tick_i = 1'b1;
    if (do_clr) begin addr_i = 2'd2; wdata_i = {4'd0, mask}; wr_en_i = 1'b1; end
    @(posedge clk);
    if (do_clr) m_flags = m_flags & ~mask;
    if (m_req) begin
      m_flags = m_flags | tap_drops(m_cnt);
      m_cnt = m_cnt + 8'd1;
    end
    m_act = m_req;
    #1 tick_i = 1'b0; wr_en_i = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick_with_clear(1'b0, 4'd0);
  endtask

  task automatic check_all(input string tag);
    push_read(2'd0, {7'd0, m_act}, tag);
    push_read(2'd1, m_cnt, tag);
    push_read(2'd2, {4'd0, m_flags}, tag);
    push_read(2'd3, {4'd0, m_en}, tag);
    push_irq(|(m_flags & m_en), tag);
  endtask

  // Monitor: compares queued expectations mid-cycle
  always @(negedge clk) begin
    if (chk_on && q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = it.is_irq ? {7'd0, irq_o} : rdata_o;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s %s: actual %02h expected %02h", it.tag,
                 it.is_irq ? "irq" : "rdata", act, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_all("R1 reset");

    ticks(3);
    check_all("R3 stopped ticks");

    reg_write(2'd0, 8'h01);
    push_read(2'd0, 8'h00, "R4 run lags before tick");
    ticks(1);
    push_read(2'd0, 8'h01, "R4 run after tick");
    push_read(2'd1, 8'h01, "R2 first step");

    ticks(7);
    check_all("R5 32Hz tap drop");
    push_irq(1'b0, "R8 flag pending but disabled");

    reg_write(2'd3, 8'h01);
    push_irq(1'b1, "R8 enable pending flag");
    reg_write(2'd2, 8'h00);
    push_read(2'd2, {4'd0, m_flags}, "R6 write zero no effect");
    reg_write(2'd2, 8'h01);
    check_all("R6 write one clears");

    ticks(32'd255 - 32'd8);
    push_read(2'd1, 8'hFF, "R2 at max");
    ticks(1);
    check_all("R2 R5 wrap all taps");

    reg_write(2'd3, 8'h0F);
    reg_write(2'd2, 8'h0F);
    ticks(7);
    reg_write(2'd2, 8'h0F);
    tick_with_clear(1'b1, 4'h1);
    check_all("R7 set wins");
    push_read(2'd2, 8'h01, "R7 flag kept");

    reg_write(2'd1, 8'h55);
    push_read(2'd1, m_cnt, "R10 count read only");

    reg_write(2'd0, 8'h00);
    push_read(2'd0, 8'h01, "R4 stop lags before tick");
    ticks(20);
    check_all("R3 stopped hold");

    reg_write(2'd0, 8'h01);
    ticks(5);
    reg_write(2'd0, 8'h03);
    check_all("R9 clear counter");
    push_read(2'd1, 8'h00, "R9 count zero");
    ticks(2);
    check_all("R9 keeps running");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule